// File: doc/BRIEF.md
# Successive-Approximation Converter Readout Sequencer

This block runs a 16-bit successive-approximation converter whose result is read back over a three-wire serial link. The convert strobe controls both the conversion and the data output: a rising strobe starts a conversion, and a falling strobe begins the readout. The sequencer raises the strobe and holds it high until the worst-case conversion time has passed. It then drops the strobe and toggles a serial clock 16 times, capturing one data bit on each rising clock edge, most significant bit first. The assembled word is presented with a one-cycle valid pulse.

Every timing limit is given as a parameter in nanoseconds. Each one is turned into a system-clock cycle count by rounding up, so every minimum is met. The limits are the strobe-high minimum, the conversion time, the delay from strobe fall to first data, the serial clock low and high phases, and the minimum spacing between conversions. Software can request a longer sample period in clock cycles. The sequencer never goes below the minimum spacing, and it never starts a conversion before the current readout has delivered its word.

Top module: `sar_readout_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `conv_strobe` is 1, `ser_clk` is 0 and `word_valid` is 0.
- R2: In every converting frame, `conv_strobe` stays high for exactly CONV_CYC cycles before it falls for readout. CONV_CYC is the conversion time rounded up to whole clock cycles and is at least one more than the strobe-high minimum. With the default parameters it is 125.
- R3: While enabled, consecutive rising edges of `conv_strobe` are exactly max(`period_cfg`, MIN_CYC) cycles apart whenever the readout fits in that span. They are never closer than MIN_CYC, and a new rising edge never occurs before the previous readout has delivered its word. MIN_CYC is 300 by default.
- R4: `ser_clk` is 0 whenever `conv_strobe` is 1.
- R5: The first rising edge of `ser_clk` comes LEAD_CYC cycles after `conv_strobe` falls. Each high phase lasts HI_CYC cycles and each later low phase lasts LO_CYC cycles. The defaults are 5, 3 and 4.
- R6: Each readout has exactly 16 rising edges of `ser_clk`. The bit on `ser_din` at the k-th rising edge becomes bit 15-k+1 of the word, so the first bit lands in bit 15 and the last in bit 0.
- R7: `word_valid` is a single-cycle pulse. It is high in the cycle that follows the 16th falling edge of `ser_clk`, and `word_data` carries the word in that cycle.
- R8: When `enable` drops during a frame, that frame completes and delivers its word. The sequencer then waits out the period and returns `conv_strobe` high with `ser_clk` low. No further rising edges, clocks or words follow while `enable` stays low.
- R9: When `enable` rises while the sequencer is idle and the period has long elapsed, `conv_strobe` is low in the following cycle and high again in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run continuous conversions while high |
| period_cfg | input | PERIOD_W | Requested sample period in clock cycles, raised to MIN_CYC if lower |
| ser_din | input | 1 | Serial result data from the converter |
| conv_strobe | output | 1 | Convert strobe; a rising edge starts a conversion, low enables the data output |
| ser_clk | output | 1 | Serial clock to the converter |
| word_valid | output | 1 | One-cycle pulse marking a new result |
| word_data | output | DATA_W | Captured result word |

## Verification
The bench builds the block with its default parameters and a 4 ns clock. This gives a 125-cycle conversion wait, serial clock phases of 5, 4 and 3 cycles, and a 300-cycle period floor, so a whole frame fits in a few hundred cycles. Requested periods of 0 and 100 exercise the clamp to the floor. A period of 301 sits one cycle above the floor, and 600 shows the hold stretching well past the readout. The converter model serves all-zero, all-one, alternating and single-bit words to catch bit-order and off-by-one shift errors.

// File: rtl/sar_readout_pkg.sv
package sar_readout_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_CNV_HI    = 3'd1,
    ST_CONV_WAIT = 3'd2,
    ST_READ      = 3'd3,
    ST_DONE      = 3'd4,
    ST_HOLD      = 3'd5
  } seq_state_t;

  // Round a nanosecond limit up to whole clock cycles.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sar_cycle_timer.sv
// Saturating count of cycles since the last strobe rising edge.
module sar_cycle_timer #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] count
);
  timeunit 1ns;
  timeprecision 100ps;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '1;                 // period treated as long expired
    end else if (restart) begin
      count <= W'(1);
    end else if (count != '1) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/sar_shift_capture.sv
// MSB-first serial-to-parallel capture.
module sar_shift_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  timeunit 1ns;
  timeprecision 100ps;

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (shift_en) begin
      word <= {word[W-2:0], din};
    end
  end
endmodule

// File: rtl/sar_sck_engine.sv
// Serial clock generator for one readout: a lead-in low phase, then
// alternating high and low phases, ending on the last falling edge.
module sar_sck_engine #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LEAD_CYC = 5,
  parameter int unsigned LO_CYC   = 4,
  parameter int unsigned HI_CYC   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sck,
  output logic sample_stb,
  output logic frame_end
);
  timeunit 1ns;
  timeprecision 100ps;
  import sar_readout_pkg::*;

  localparam int unsigned PH_MAX = umax(LEAD_CYC, umax(LO_CYC, HI_CYC));
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
  localparam int unsigned BIT_W  = $clog2(DATA_W);

  logic [PH_W-1:0]  phase;
  logic [PH_W-1:0]  phase_last;
  logic [BIT_W-1:0] bit_idx;
  logic             first_q;
  logic             tick;

  always_comb begin
    if (sck)          phase_last = PH_W'(HI_CYC - 1);
    else if (first_q) phase_last = PH_W'(LEAD_CYC - 1);
    else              phase_last = PH_W'(LO_CYC - 1);
  end

  assign tick       = run && (phase == phase_last);
  assign sample_stb = tick && !sck;
  assign frame_end  = tick && sck && (bit_idx == BIT_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase   <= '0;
      sck     <= 1'b0;
      bit_idx <= '0;
      first_q <= 1'b1;
    end else if (tick) begin
      phase <= '0;
      sck   <= ~sck;
      if (sck) begin
        bit_idx <= bit_idx + 1'b1;
      end else begin
        first_q <= 1'b0;
      end
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sar_readout_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned PERIOD_W      = 12,
  parameter int unsigned T_CNVH_NS     = 10,
  parameter int unsigned T_CONV_NS     = 500,
  parameter int unsigned T_CYC_NS      = 1200,
  parameter int unsigned T_EN_NS       = 18,
  parameter int unsigned T_SCK_LO_NS   = 16,
  parameter int unsigned T_SCK_HI_NS   = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period_cfg,
  input  logic                ser_din,
  output logic                conv_strobe,
  output logic                ser_clk,
  output logic                word_valid,
  output logic [DATA_W-1:0]   word_data
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned STROBE_CYC = umax(ns_to_cycles(T_CNVH_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned CONV_CYC   = umax(ns_to_cycles(T_CONV_NS, CLK_PERIOD_NS), STROBE_CYC + 1);
  localparam int unsigned MIN_CYC    = ns_to_cycles(T_CYC_NS, CLK_PERIOD_NS);
  localparam int unsigned LO_CYC     = umax(ns_to_cycles(T_SCK_LO_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned HI_CYC     = umax(ns_to_cycles(T_SCK_HI_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned LEAD_CYC   = umax(ns_to_cycles(T_EN_NS, CLK_PERIOD_NS), LO_CYC);
  localparam int unsigned CNT_W      = umax($clog2(MIN_CYC + 1),
                                            umax($clog2(CONV_CYC + 1), PERIOD_W)) + 1;

  seq_state_t        state, state_next;
  logic [CNT_W-1:0]  since_edge;
  logic [CNT_W-1:0]  cfg_ext;
  logic [CNT_W-1:0]  period_eff;
  logic              strobe_next;
  logic              strobe_rise;
  logic              bit_stb;
  logic              last_fall;
  logic [DATA_W-1:0] shift_word;

  // Requested period, never below the converter's minimum spacing.
  assign cfg_ext    = CNT_W'(period_cfg);
  assign period_eff = (cfg_ext > CNT_W'(MIN_CYC)) ? cfg_ext : CNT_W'(MIN_CYC);

  always_comb begin
    state_next = state;
    unique case (state)
      ST_IDLE:      if (enable) state_next = ST_HOLD;
      ST_CNV_HI:    if (since_edge >= CNT_W'(STROBE_CYC)) state_next = ST_CONV_WAIT;
      ST_CONV_WAIT: if (since_edge >= CNT_W'(CONV_CYC)) state_next = ST_READ;
      ST_READ:      if (last_fall) state_next = ST_DONE;
      ST_DONE:      state_next = ST_HOLD;
      ST_HOLD:      if (since_edge >= period_eff) state_next = enable ? ST_CNV_HI : ST_IDLE;
      default:      state_next = ST_IDLE;
    endcase
  end

  // The strobe is high while idle and throughout the conversion.
  assign strobe_next = (state_next == ST_IDLE) || (state_next == ST_CNV_HI) ||
                       (state_next == ST_CONV_WAIT);
  assign strobe_rise = strobe_next && !conv_strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      conv_strobe <= 1'b1;
      word_valid  <= 1'b0;
      word_data   <= '0;
    end else begin
      state       <= state_next;
      conv_strobe <= strobe_next;
      word_valid  <= last_fall;
      if (last_fall) word_data <= shift_word;
    end
  end

  sar_cycle_timer #(.W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (strobe_rise),
    .count   (since_edge)
  );

  sar_sck_engine #(
    .DATA_W   (DATA_W),
    .LEAD_CYC (LEAD_CYC),
    .LO_CYC   (LO_CYC),
    .HI_CYC   (HI_CYC)
  ) u_sck (
    .clk        (clk),
    .rst        (rst),
    .run        (state == ST_READ),
    .sck        (ser_clk),
    .sample_stb (bit_stb),
    .frame_end  (last_fall)
  );

  sar_shift_capture #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (bit_stb),
    .din      (ser_din),
    .word     (shift_word)
  );
endmodule

// File: rtl/sar_readout_checker.sv
module sar_readout_checker #(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned T_CNVH_NS     = 10,
  parameter int unsigned T_CONV_NS     = 500,
  parameter int unsigned T_CYC_NS      = 1200
) (
  input logic clk,
  input logic rst,
  input logic conv_strobe,
  input logic ser_clk,
  input logic word_valid
);
  timeunit 1ns;
  timeprecision 100ps;
  import sar_readout_pkg::*;

  localparam int unsigned STROBE_CYC = umax(ns_to_cycles(T_CNVH_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned CONV_CYC   = umax(ns_to_cycles(T_CONV_NS, CLK_PERIOD_NS), STROBE_CYC + 1);
  localparam int unsigned MIN_CYC    = ns_to_cycles(T_CYC_NS, CLK_PERIOD_NS);
  localparam int unsigned CW         = $clog2(MIN_CYC + CONV_CYC + 1) + 2;
  localparam int unsigned RW         = $clog2(DATA_W + 1) + 1;

  logic          strobe_q, sck_q, rd_busy;
  logic [CW-1:0] gap_cnt, hi_cnt;
  logic [RW-1:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b1;
      sck_q    <= 1'b0;
      gap_cnt  <= '1;
      hi_cnt   <= '1;
      rise_cnt <= '0;
      rd_busy  <= 1'b0;
    end else begin
      strobe_q <= conv_strobe;
      sck_q    <= ser_clk;
      if (conv_strobe && !strobe_q) gap_cnt <= CW'(1);
      else if (gap_cnt != '1)       gap_cnt <= gap_cnt + 1'b1;
      if (!conv_strobe)             hi_cnt <= '0;
      else if (hi_cnt != '1)        hi_cnt <= hi_cnt + 1'b1;
      if (!conv_strobe && strobe_q)   rise_cnt <= '0;
      else if (ser_clk && !sck_q)     rise_cnt <= rise_cnt + 1'b1;
      if (word_valid)                 rd_busy <= 1'b0;
      else if (ser_clk && !sck_q)     rd_busy <= 1'b1;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (conv_strobe && !ser_clk && !word_valid));

  p_conv_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (!conv_strobe && strobe_q) |-> (hi_cnt >= CW'(CONV_CYC)));

  p_min_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (conv_strobe && !strobe_q) |-> (gap_cnt >= CW'(MIN_CYC)));

  p_no_cut_read_r3: assert property (@(posedge clk) disable iff (rst)
    (conv_strobe && !strobe_q) |-> !rd_busy);

  p_sck_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    conv_strobe |-> !ser_clk);

  p_bit_count_r6: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (rise_cnt == RW'(DATA_W)));

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  p_valid_after_fall_r7: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (sck_q && !ser_clk));
endmodule

bind sar_readout_ctrl sar_readout_checker #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .DATA_W        (DATA_W),
  .T_CNVH_NS     (T_CNVH_NS),
  .T_CONV_NS     (T_CONV_NS),
  .T_CYC_NS      (T_CYC_NS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .conv_strobe (conv_strobe),
  .ser_clk     (ser_clk),
  .word_valid  (word_valid)
);

// File: tb/sim_sar_readout_ctrl.sv
module sim_sar_readout_ctrl;
  timeunit 1ns;
  timeprecision 100ps;

  // Expected timing, worked out from the requirements for a 4 ns clock.
  localparam int CLK_NS   = 4;
  localparam int EXP_CONV = (500 + CLK_NS - 1) / CLK_NS;   // 125
  localparam int EXP_LEAD = (18 + CLK_NS - 1) / CLK_NS;    // 5
  localparam int EXP_LO   = (16 + CLK_NS - 1) / CLK_NS;    // 4
  localparam int EXP_HI   = (11 + CLK_NS - 1) / CLK_NS;    // 3
  localparam int EXP_MIN  = (1200 + CLK_NS - 1) / CLK_NS;  // 300

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [11:0] period_cfg = '0;
  logic        ser_din = 1'b0;
  logic        conv_strobe, ser_clk, word_valid;
  logic [15:0] word_data;

  always #2 clk = ~clk;

  sar_readout_ctrl u0 (
    .clk(clk), .rst(rst), .enable(enable), .period_cfg(period_cfg),
    .ser_din(ser_din), .conv_strobe(conv_strobe), .ser_clk(ser_clk),
    .word_valid(word_valid), .word_data(word_data)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Converter model and scoreboard driver.
  logic [15:0] pat_q[$];
  logic [15:0] exp_q[$];
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] cur  = '0;
  int          idx  = 0;
  bit          pending = 0;

  always @(negedge conv_strobe) begin
    if (pat_q.size() > 0) cur = pat_q.pop_front();
    else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cur  = lfsr;
    end
    idx     = 15;
    ser_din = cur[15];
    pending = 1;
  end

  always @(posedge ser_clk) begin
    if (pending) begin
      exp_q.push_back(cur);
      pending = 0;
    end
  end

  always @(negedge ser_clk) begin
    idx     = idx - 1;
    ser_din = (idx >= 0) ? cur[idx] : 1'b0;
  end

  // Monitor: timing checks and scoreboard compare.
  int cyc = 0;
  logic cnv_p = 1'b1, sck_p = 1'b0, val_p = 1'b0;
  int t_rise = 0, t_fall = 0, t_srise = 0, t_sfall = 0;
  bit have_rise = 0;
  int n_sck_rise = 0;
  int n_valid = 0;
  int n_cnv_rise = 0;
  bit check_period = 0;
  int exp_int = EXP_MIN;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (conv_strobe && !cnv_p) begin
        if (have_rise && check_period)
          check(cyc - t_rise == exp_int, "R3", "strobe rise spacing", cyc - t_rise, exp_int);
        if (n_sck_rise > 0)
          check(n_sck_rise == 16, "R6", "clock rises before next strobe", n_sck_rise, 16);
        t_rise = cyc; have_rise = 1; n_sck_rise = 0; n_cnv_rise++;
      end
      if (!conv_strobe && cnv_p) begin
        t_fall = cyc; n_sck_rise = 0;
      end
      if (ser_clk && !sck_p) begin
        check(!conv_strobe, "R4", "clock high with strobe high", conv_strobe, 0);
        if (n_sck_rise == 0) begin
          check(have_rise && (t_fall - t_rise == EXP_CONV), "R2", "strobe high width",
                t_fall - t_rise, EXP_CONV);
          check(cyc - t_fall == EXP_LEAD, "R5", "lead-in low phase", cyc - t_fall, EXP_LEAD);
        end else begin
          check(cyc - t_sfall == EXP_LO, "R5", "low phase", cyc - t_sfall, EXP_LO);
        end
        t_srise = cyc; n_sck_rise++;
      end
      if (!ser_clk && sck_p) begin
        check(cyc - t_srise == EXP_HI, "R5", "high phase", cyc - t_srise, EXP_HI);
        t_sfall = cyc;
      end
      if (word_valid) begin
        check(!val_p, "R7", "valid wider than one cycle", 1, 0);
        check(sck_p && !ser_clk, "R7", "valid not right after last fall", ser_clk, 0);
        check(n_sck_rise == 16, "R6", "clock rises in frame", n_sck_rise, 16);
        if (exp_q.size() == 0) check(0, "R6", "word with nothing expected", word_data, -1);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(word_data == e, "R6", "captured word", word_data, e);
        end
        n_valid++;
      end
    end
    cnv_p = conv_strobe; sck_p = ser_clk; val_p = word_valid;
  end

  task automatic wait_words(input int n);
    int target;
    target = n_valid + n;
    while (n_valid < target) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int v0, r0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(conv_strobe == 1'b1, "R1", "reset strobe", conv_strobe, 1);
    check(ser_clk == 1'b0, "R1", "reset clock", ser_clk, 0);
    check(word_valid == 1'b0, "R1", "reset valid", word_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(conv_strobe && !ser_clk && !word_valid, "R1", "first cycle after reset", conv_strobe, 1);

    // Clamped period with edge-case words.
    pat_q.push_back(16'h0000); pat_q.push_back(16'hFFFF); pat_q.push_back(16'h8001);
    pat_q.push_back(16'hA5A5); pat_q.push_back(16'h7FFE); pat_q.push_back(16'h0001);
    period_cfg = 12'd0; exp_int = EXP_MIN; check_period = 1; enable = 1'b1;
    wait_words(8);

    period_cfg = 12'd600; exp_int = 600;          // R3 stretched hold
    wait_words(3);
    period_cfg = 12'd100; exp_int = EXP_MIN;      // R3 below floor
    wait_words(3);
    period_cfg = 12'd301; exp_int = 301;          // R3 one above floor
    wait_words(2);
    period_cfg = 12'd0; exp_int = EXP_MIN;
    wait_words(1);

    // R8: drop enable in the middle of a readout.
    while (!ser_clk) @(negedge clk);
    v0 = n_valid; r0 = n_cnv_rise;
    enable = 1'b0;
    repeat (800) @(negedge clk);
    check(n_valid == v0 + 1, "R8", "words after disable", n_valid - v0, 1);
    check(n_cnv_rise == r0 + 1, "R8", "strobe rises after disable", n_cnv_rise - r0, 1);
    check(conv_strobe == 1'b1, "R8", "idle strobe level", conv_strobe, 1);
    check(ser_clk == 1'b0, "R8", "idle clock level", ser_clk, 0);
    check(exp_q.size() == 0, "R8", "unread expected words", exp_q.size(), 0);

    // R9: restart from idle.
    check_period = 0;
    enable = 1'b1;
    @(negedge clk);
    check(conv_strobe == 1'b0, "R9", "strobe low after enable", conv_strobe, 0);
    @(negedge clk);
    check(conv_strobe == 1'b1, "R9", "strobe high one cycle later", conv_strobe, 1);
    pat_q.push_back(16'h5A5A); pat_q.push_back(16'h4000);
    wait_words(1);
    check_period = 1;
    wait_words(3);

    enable = 1'b0;
    repeat (700) @(negedge clk);
    check(exp_q.size() == 0, "R8", "words left at end", exp_q.size(), 0);
    summary();
  end
endmodule